// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit control and status words behind a simple register bus. The bus has one request per cycle: a valid strobe, a write flag, a 12-bit byte address and write data. The address space covers 4 KiB. Only the lowest 512 words have storage behind them. An access above that range changes nothing and raises a one-cycle error pulse.

One word slot, at byte offset 0xF00, is a command port. A write of a command code there raises a single-cycle request to the system: either a whole-system reset or a power-off. The slot lies outside the storage, but the command is decoded before the range check, so it still acts. A write to the slot also raises the error pulse, because it has no storage behind it.

Four words load fixed non-zero values on reset. Three status words always read with bits 29:28 forced high. Read data comes back one cycle after the read strobe, with a response-valid flag.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121 and word 0x43 holds 0x05F40121. Every other word holds 0. Reset drives all outputs low.
- R2: A write whose word index is below 512 stores all 32 data bits at that index. A read returns `rsp_valid`=1 and the data in the cycle after the read strobe.
- R3: Reads of byte offsets 0x100, 0x108 and 0x10C return the stored word OR 0x30000000. Reads of other offsets, such as 0x104, are not altered.
- R4: A write of 1 or 2 to offset 0xF00 gives `sys_reset_req`=1 for exactly the one cycle after the write. A write of 3 gives `sys_off_req`=1 for that one cycle. A write of any other value, such as 0 or 4, raises neither request. The two requests are never high together.
- R5: The command at 0xF00 acts even though its word index 0x3C0 has no storage. That write also raises `err_pulse`.
- R6: A write with word index 512 or above changes no stored word and raises `err_pulse` for the one following cycle. For example, offset 0x900 does not alias onto word 0x40.
- R7: A read with word index 512 or above returns 0 with `rsp_valid`=1 and raises `err_pulse` for one cycle. Accesses within range never raise `err_pulse`.
- R8: Address bits 1:0 are ignored. The word index is `req_addr[11:2]`.
- R9: An error leaves no lasting state. The access that follows an error is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address in the 4 KiB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| err_pulse | output | 1 | One-cycle pulse after an out-of-range access |
| sys_reset_req | output | 1 | One-cycle whole-system reset request |
| sys_off_req | output | 1 | One-cycle power-off request |

## Verification
The embedded properties check the following on every cycle:
- the two system requests are never high together;
- each request, error pulse and read response traces back to an access of the matching kind in the previous cycle;
- an out-of-range read always returns zero.

Other behaviours depend on values or on the history of the storage, so only the bench scenarios can show them:
- the reset contents;
- the forced status bits;
- the full-width storage of written data;
- the mapping of each command value, 0 to 4;
- the absence of aliasing for discarded writes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BUS_AW    = 12;
  localparam int unsigned NUM_WORDS = 512;
  localparam int unsigned CMD_SLOT  = 'h3C0;
  localparam logic [WORD_W-1:0] STATUS_FORCE = 32'h3000_0000;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_RESET = 2'd1,
    CMD_OFF   = 2'd2
  } sys_cmd_e;

  function automatic logic [WORD_W-1:0] init_word(input int unsigned slot);
    case (slot)
      'h40:    init_word = 32'h05F2_0121;
      'h41:    init_word = 32'h0000_0002;
      'h42:    init_word = 32'h05F3_0121;
      'h43:    init_word = 32'h05F4_0121;
      default: init_word = '0;
    endcase
  endfunction

  function automatic logic is_status_slot(input int unsigned slot);
    is_status_slot = (slot == 'h40) || (slot == 'h42) || (slot == 'h43);
  endfunction

  function automatic sys_cmd_e cmd_of(input logic [WORD_W-1:0] code);
    if (code == 32'd1 || code == 32'd2) cmd_of = CMD_RESET;
    else if (code == 32'd3)             cmd_of = CMD_OFF;
    else                                cmd_of = CMD_IDLE;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int unsigned ADDR_W = sysctl_pkg::BUS_AW,
  parameter int unsigned DEPTH  = sysctl_pkg::NUM_WORDS,
  parameter int unsigned CMD_IX = sysctl_pkg::CMD_SLOT,
  localparam int unsigned IX_W  = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IX_W-1:0]   word_ix,
  output logic              in_range,
  output logic              cmd_hit,
  output logic              force_hit
);
  logic [1:0] unused_byte_lane;

  assign unused_byte_lane = addr[1:0];
  assign word_ix          = addr[ADDR_W-1:2];

  always_comb begin
    in_range  = (int'(word_ix) < int'(DEPTH));
    cmd_hit   = (int'(word_ix) == int'(CMD_IX));
    force_hit = sysctl_pkg::is_status_slot(int'(word_ix));
  end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store #(
  parameter int unsigned DEPTH  = sysctl_pkg::NUM_WORDS,
  parameter int unsigned DATA_W = sysctl_pkg::WORD_W,
  localparam int unsigned IX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IX_W-1:0]   wr_ix,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IX_W-1:0]   rd_ix,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= sysctl_pkg::init_word(i);
    end else if (wr_en) begin
      mem_q[wr_ix] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_ix];
endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd #(
  parameter int unsigned DATA_W = sysctl_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [DATA_W-1:0] code,
  output logic              reset_req,
  output logic              off_req
);
  import sysctl_pkg::*;

  sys_cmd_e cmd_d;
  logic     rst_d, off_d, rst_q, off_q;

  always_comb begin
    cmd_d = fire ? cmd_of(code) : CMD_IDLE;
    rst_d = (cmd_d == CMD_RESET);
    off_d = (cmd_d == CMD_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      off_q <= 1'b0;
    end else begin
      rst_q <= rst_d;
      off_q <= off_d;
    end
  end

  assign reset_req = rst_q;
  assign off_req   = off_q;

  a_r4_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reset_req && off_req));
  a_r4_reset_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(fire));
  a_r4_off_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |-> $past(fire));
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int unsigned ADDR_W = sysctl_pkg::BUS_AW,
  parameter int unsigned DATA_W = sysctl_pkg::WORD_W,
  parameter int unsigned DEPTH  = sysctl_pkg::NUM_WORDS,
  localparam int unsigned IX_W  = ADDR_W - 2,
  localparam int unsigned MEM_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err_pulse,
  output logic              sys_reset_req,
  output logic              sys_off_req
);
  logic [IX_W-1:0]   word_ix;
  logic              in_range, cmd_hit, force_hit;
  logic              wr_en, rd_en;
  logic [DATA_W-1:0] store_rd;
  logic              rvalid_d, rvalid_q, err_d, err_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic [IX_W-MEM_W-1:0] unused_hi_ix;

  sysctl_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dec (
    .addr(req_addr), .word_ix(word_ix), .in_range(in_range),
    .cmd_hit(cmd_hit), .force_hit(force_hit)
  );

  assign unused_hi_ix = word_ix[IX_W-1:MEM_W];
  assign wr_en = req_valid && req_write && in_range;
  assign rd_en = req_valid && !req_write;

  sysctl_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ix(word_ix[MEM_W-1:0]),
    .wr_data(req_wdata), .rd_ix(word_ix[MEM_W-1:0]), .rd_data(store_rd)
  );

  sysctl_cmd #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .fire(req_valid && req_write && cmd_hit),
    .code(req_wdata), .reset_req(sys_reset_req), .off_req(sys_off_req)
  );

  always_comb begin
    rvalid_d = rd_en;
    err_d    = req_valid && !in_range;
    rdata_d  = rdata_q;
    if (rd_en) begin
      if (!in_range)      rdata_d = '0;
      else if (force_hit) rdata_d = store_rd | sysctl_pkg::STATUS_FORCE;
      else                rdata_d = store_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      err_q    <= err_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;
  assign err_pulse = err_q;

  a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  a_r6_err_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(req_valid));
  a_r7_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(!in_range)) |-> (rsp_rdata == '0));
  a_r7_inrange_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && in_range) |-> !err_pulse);
endmodule

// File: tb/sim_sysctl_regfile.sv
module sim_sysctl_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, err_pulse, sys_reset_req, sys_off_req;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad = 0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  sysctl_regfile u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .err_pulse(err_pulse),
    .sys_reset_req(sys_reset_req), .sys_off_req(sys_off_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) check("R2 unexpected rsp", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, rsp_rdata, e.val);
      end
    end
  end

  task automatic acc(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     input logic e_err, input logic e_rst, input logic e_off, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (!wr) sb_q.push_back('{d, tag});
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
    check({tag, " err"}, {31'd0, err_pulse}, {31'd0, e_err});
    check({tag, " rst"}, {31'd0, sys_reset_req}, {31'd0, e_rst});
    check({tag, " off"}, {31'd0, sys_off_req}, {31'd0, e_off});
  endtask

  task automatic quiet(input string tag);
    @(posedge clk); #1;
    check({tag, " pulse end"}, {29'd0, sys_reset_req, sys_off_req, err_pulse}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", {28'd0, rsp_valid, err_pulse, sys_reset_req, sys_off_req}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    acc(0, 12'h100, 32'h35F2_0121, 0, 0, 0, "R1 R3 word40");
    acc(0, 12'h104, 32'h0000_0002, 0, 0, 0, "R1 word41");
    acc(0, 12'h108, 32'h35F3_0121, 0, 0, 0, "R1 R3 word42");
    acc(0, 12'h10C, 32'h35F4_0121, 0, 0, 0, "R1 R3 word43");
    acc(0, 12'h000, 32'h0, 0, 0, 0, "R1 word0");
    acc(0, 12'h7FC, 32'h0, 0, 0, 0, "R1 word1ff");

    acc(1, 12'h010, 32'hA5A5_5A5A, 0, 0, 0, "R2 wr4");
    acc(0, 12'h010, 32'hA5A5_5A5A, 0, 0, 0, "R2 rd4");
    acc(1, 12'h7FC, 32'hFFFF_FFFF, 0, 0, 0, "R2 wr1ff");
    acc(0, 12'h7FC, 32'hFFFF_FFFF, 0, 0, 0, "R2 rd1ff");

    acc(1, 12'h100, 32'h0, 0, 0, 0, "R3 wr40");
    acc(0, 12'h100, 32'h3000_0000, 0, 0, 0, "R3 rd40");
    acc(1, 12'h104, 32'h0, 0, 0, 0, "R3 wr41");
    acc(0, 12'h104, 32'h0, 0, 0, 0, "R3 rd41 unforced");
    acc(1, 12'h108, 32'hCFFF_FFFF, 0, 0, 0, "R3 wr42");
    acc(0, 12'h108, 32'hFFFF_FFFF, 0, 0, 0, "R3 rd42");

    acc(1, 12'h023, 32'h0000_0011, 0, 0, 0, "R8 wr lowbits");
    acc(0, 12'h020, 32'h0000_0011, 0, 0, 0, "R8 rd aligned");
    acc(0, 12'h021, 32'h0000_0011, 0, 0, 0, "R8 rd offset1");

    for (int v = 0; v <= 4; v++) begin
      acc(1, 12'hF00, 32'(v), 1, (v == 1 || v == 2), (v == 3), "R4 R5 cmd");
      quiet("R4 cmd");
    end

    acc(1, 12'h900, 32'hDEAD_BEEF, 1, 0, 0, "R6 oor wr");
    quiet("R6");
    acc(0, 12'h100, 32'h3000_0000, 0, 0, 0, "R6 no alias");
    acc(1, 12'hFFC, 32'h1234_5678, 1, 0, 0, "R6 oor wr top");
    acc(0, 12'h7FC, 32'hFFFF_FFFF, 0, 0, 0, "R6 last word kept");

    acc(0, 12'h900, 32'h0, 1, 0, 0, "R7 oor rd");
    acc(0, 12'hF00, 32'h0, 1, 0, 0, "R7 cmd slot rd");
    acc(0, 12'h010, 32'hA5A5_5A5A, 0, 0, 0, "R9 after error");

    repeat (3) @(posedge clk);
    #1;
    check("R2 all responses seen", sb_q.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule